// File: doc/BRIEF.md
# Two-Channel Time-Shared Bi-Phase Mark Line Encoder

This block merges two slow control streams onto one serial line for an optical link. Channel A carries trigger-accept bits and channel B carries command bits. Each stream delivers one bit per machine cycle. The encoder runs on a symbol clock at four times the machine rate (160.32 MBd against a 40.08 MHz machine clock). It splits every machine cycle into two bit slots of two symbols each. Channel A owns the first slot and channel B the second.

Each slot is coded in bi-phase mark form. The line always changes level where a slot begins. It changes level again halfway through the slot only when the slot's bit is a one. The result carries timing at every slot edge and stays DC-balanced.

A one-cycle strobe, generated in step with the machine clock, marks the first symbol of a machine cycle. The first strobe after reset starts the encoder. Later strobes realign the internal symbol phase. Between strobes the phase runs freely and wraps every four symbols.

Top module: `tdm_bpm_encoder`

## Requirements
- R1: After reset, `line_o` is low (parameter `START_LEVEL`, default 0). It stays at that level, whatever `a_bit_i` and `b_bit_i` do, until the first symbol-clock edge at which `cyc_strobe_i` is high.
- R2: Each frame is four symbols, emitted on four consecutive symbol-clock edges in the order position 0, 1, 2, 3. Positions 0 and 1 form the channel A slot and positions 2 and 3 form the channel B slot. The position 0 symbol appears on the edge at which the frame is started.
- R3: At position 0 and at position 2 (each slot start), the line level is inverted relative to the previous symbol.
- R4: At position 1 the line inverts if and only if the A bit of the frame is 1. At position 3 it inverts if and only if the B bit is 1. A bit of 0 holds the level.
- R5: Both channel bits are captured only on the position 0 edge. Changes on `a_bit_i` or `b_bit_i` during positions 1 to 3 do not affect the frame.
- R6: Without a new strobe, the phase wraps from position 3 to position 0. Fresh bits are then captured every fourth symbol clock.
- R7: A strobe at any edge forces that edge to position 0, abandoning the frame in progress.
- R8: While running, the line never holds the same level for more than two consecutive symbols. At every slot boundary, the running count of high minus low symbols since start stays within plus or minus 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sym_i | input | 1 | Symbol clock, four times the machine clock and phase-locked to it |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| cyc_strobe_i | input | 1 | High for one symbol clock at the first symbol of a machine cycle |
| a_bit_i | input | 1 | Channel A (trigger-accept) bit for the current machine cycle |
| b_bit_i | input | 1 | Channel B (command) bit for the current machine cycle |
| line_o | output | 1 | Serial bi-phase mark line output |

## Verification
The bench builds the encoder with its default `START_LEVEL` of 0. This makes the reset level, the idle hold before the first strobe and the absolute symbol values directly comparable against a level model kept in the bench. With that fixed starting point, the run-length and disparity bounds of R8 can be tracked from the very first symbol. These bounds are tracked across all four A/B bit combinations, a pseudo-random bit stream, free-running frames without a strobe, and frames cut short at a slot boundary by a realigning strobe.

// File: rtl/tdm_bpm_encoder.sv
module tdm_bpm_encoder #(
  parameter logic START_LEVEL = 1'b0
) (
  input  logic clk_sym_i,
  input  logic rst_n_i,
  input  logic cyc_strobe_i,
  input  logic a_bit_i,
  input  logic b_bit_i,
  output logic line_o
);

  logic [1:0] phase_q;
  logic [1:0] pos_now;
  logic [1:0] age_q;
  logic       running_q;
  logic       a_q, b_q;
  logic       line_q;
  logic       go;

  assign go      = running_q | cyc_strobe_i;
  assign pos_now = cyc_strobe_i ? 2'd0 : phase_q + 2'd1;
  assign line_o  = line_q;

  always_ff @(posedge clk_sym_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      phase_q   <= 2'd3;
      age_q     <= 2'd0;
      running_q <= 1'b0;
      a_q       <= 1'b0;
      b_q       <= 1'b0;
      line_q    <= START_LEVEL;
    end else if (go) begin
      running_q <= 1'b1;
      phase_q   <= pos_now;
      if (age_q != 2'd2) age_q <= age_q + 2'd1;
      case (pos_now)
        2'd0: begin
          line_q <= ~line_q;
          a_q    <= a_bit_i;
          b_q    <= b_bit_i;
        end
        2'd1: line_q <= line_q ^ a_q;
        2'd2: line_q <= ~line_q;
        default: line_q <= line_q ^ b_q;
      endcase
    end
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk_sym_i) disable iff (!rst_n_i)
    (!running_q && !cyc_strobe_i) |=> (line_o == START_LEVEL));

  // R3
  slot_edge_chk: assert property (@(posedge clk_sym_i) disable iff (!rst_n_i)
    (go && (pos_now == 2'd0 || pos_now == 2'd2)) |=> (line_o != $past(line_o)));

  // R4 R5
  a_mid_chk: assert property (@(posedge clk_sym_i) disable iff (!rst_n_i)
    (go && pos_now == 2'd0) ##1 !cyc_strobe_i |=> ((line_o != $past(line_o)) == $past(a_bit_i, 2)));

  // R6
  wrap_chk: assert property (@(posedge clk_sym_i) disable iff (!rst_n_i)
    (running_q && !cyc_strobe_i) |=> (phase_q == $past(phase_q) + 2'd1));

  // R7
  realign_chk: assert property (@(posedge clk_sym_i) disable iff (!rst_n_i)
    cyc_strobe_i |=> (phase_q == 2'd0 && running_q));

  // R8
  run_len_chk: assert property (@(posedge clk_sym_i) disable iff (!rst_n_i)
    (running_q && age_q == 2'd2 && line_o == $past(line_o)) |=> (line_o != $past(line_o)));

endmodule

// File: tb/tdm_bpm_encoder_tb_top.sv
module tdm_bpm_encoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0;
  logic a_in = 1'b0;
  logic b_in = 1'b0;
  logic line;

  int checks = 0;
  int errors = 0;
  logic exp_line = 1'b0;
  int   disp = 0;
  int   run = 0;
  logic prev_sym = 1'b0;
  logic started = 1'b0;

  tdm_bpm_encoder dut_i (
    .clk_sym_i(clk), .rst_n_i(rst_n), .cyc_strobe_i(strobe),
    .a_bit_i(a_in), .b_bit_i(b_in), .line_o(line)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: line=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: value=%0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // Drives one frame of nsym symbols; first symbol carries a strobe if use_strobe.
  // If scramble, the input bits are inverted after the position 0 edge (R5).
  task automatic frame(input logic a, input logic b, input int nsym,
                       input bit use_strobe, input bit scramble, input string req);
    for (int p = 0; p < nsym; p++) begin
      strobe = use_strobe && (p == 0);
      a_in = (scramble && p > 0) ? ~a : a;
      b_in = (scramble && p > 0) ? ~b : b;
      @(negedge clk);
      case (p)
        0, 2: exp_line = ~exp_line;
        1: exp_line = exp_line ^ a;
        default: exp_line = exp_line ^ b;
      endcase
      check(req, line, exp_line);
      disp += line ? 1 : -1;
      if (started && line == prev_sym) run++; else run = 1;
      started = 1'b1;
      prev_sym = line;
      check_int("R8 run length", run, 1, 2);
      if (p == 1 || p == 3) check_int("R8 disparity", disp, -2, 2);
    end
    strobe = 1'b0;
  endtask

  task automatic test_reset_idle();
    @(negedge clk);
    check("R1 reset level", line, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      a_in = i[0]; b_in = ~i[1];
      @(negedge clk);
      check("R1 idle before strobe", line, 1'b0);
    end
  endtask

  task automatic test_combos();
    frame(1'b0, 1'b0, 4, 1, 0, "R2 R3 R4 a0 b0");
    frame(1'b1, 1'b0, 4, 1, 0, "R4 a1 b0");
    frame(1'b0, 1'b1, 4, 1, 0, "R4 a0 b1");
    frame(1'b1, 1'b1, 4, 1, 0, "R4 a1 b1");
  endtask

  task automatic test_ignore_changes();
    frame(1'b1, 1'b0, 4, 1, 1, "R5 late change ignored");
    frame(1'b0, 1'b1, 4, 1, 1, "R5 late change ignored");
  endtask

  task automatic test_free_run();
    frame(1'b1, 1'b1, 4, 0, 0, "R6 wrap without strobe");
    frame(1'b0, 1'b1, 4, 0, 0, "R6 wrap without strobe");
    frame(1'b1, 1'b0, 4, 0, 0, "R6 wrap without strobe");
  endtask

  task automatic test_realign();
    frame(1'b1, 1'b1, 2, 1, 0, "R7 partial frame");
    frame(1'b0, 1'b1, 4, 1, 0, "R7 strobe restarts at position 0");
    frame(1'b0, 1'b0, 2, 0, 0, "R7 partial free frame");
    frame(1'b1, 1'b0, 4, 1, 0, "R7 strobe restarts at position 0");
  endtask

  task automatic test_stream();
    logic [7:0] lfsr = 8'hA5;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      frame(lfsr[0], lfsr[3], 4, (i % 3) == 0, 0, "R8 R4 stream");
    end
  endtask

  initial begin
    fork
      begin
        test_reset_idle();
        test_combos();
        test_ignore_changes();
        test_free_run();
        test_realign();
        test_stream();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule